// File: doc/BRIEF.md
# Boundary-Scan Instruction Decode and Cell Chain for an Octal Inverting Buffer

This block sits between an external test-access-port state machine and an eight-bit inverting buffer with two active-low output-enable groups. It gets one-cycle strobes for the data-register capture, shift and update states and for the instruction-update state. It also gets the 8-bit instruction value that the TAP has latched. From these it decides which scan register sits between TDI and TDO: the 18-cell boundary register or the one-bit bypass register. It also decides how the device pins behave: normal buffering, test mode, or all outputs released to high impedance.

The boundary chain holds one cell for each data input, one for each output-enable input and one for each data output. In normal operation the pins feed the inverters directly. In test mode the input cells' update latches replace the pins at the core, and the output cells' update latches drive the output pins. The output pins are modelled as a data vector plus a per-bit enable. Any instruction code that is not decoded maps to bypass.

Top module: `tbuf_scan_wrap`

## Requirements
- R1: After reset the active instruction is bypass with normal mode: a one-bit capture/shift yields 0, pin_y equals ~pin_a, and pin_y_oe bits 3:0 equal ~pin_oe_n[0] and bits 7:4 equal ~pin_oe_n[1].
- R2: Bit 7 of ir_val is ignored: codes 0x80 to 0xFF behave exactly like the code with bit 7 cleared.
- R3: Low-seven-bit codes 0x00 and 0x03 select the boundary register and put the device in test mode.
- R4: Code 0x02 selects the boundary register, and the pins keep normal buffering.
- R5: Code 0x01 and every code other than 0x00, 0x02, 0x03, 0x06 and 0x07 select bypass with normal mode.
- R6: Code 0x06 selects bypass and forces every bit of pin_y_oe to 0.
- R7: Code 0x07 selects bypass and drives pin_y from the output-cell latches, with enables derived from the enable-cell latches.
- R8: The bypass register loads 0 on cap_dr and then passes tdi to tdo with one cycle of delay on each shift_dr cycle.
- R9: On cap_dr with the boundary register selected, the chain loads a vector whose bits 1:0 are pin_oe_n, bits 9:2 are pin_a and bits 17:10 are the core output. tdo shows chain bit 0, and each shift moves tdi into bit 17 and every bit one place toward bit 0.
- R10: In test mode the core inverters take their data and enables from the input-cell latches (bits 9:2 and 1:0), and pin_y equals the output-cell latches (bits 17:10), so the core output is ~latch[9:2].
- R11: The update latches load the chain only on upd_dr while the boundary register is selected. They hold through capture, shift and any scan done in bypass.
- R12: A new ir_val value takes effect only on upd_ir. Until then both the selected register and the mode stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low test-logic reset |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| upd_ir | input | 1 | Update-IR strobe |
| ir_val | input | 8 | Latched instruction value |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial output of the selected register |
| pin_a | input | 8 | Data input pins |
| pin_oe_n | input | 2 | Active-low enables, one per nibble |
| pin_y | output | 8 | Output pin data |
| pin_y_oe | output | 8 | Per-bit output drive enable |

## Verification
The hardest case is clamp behaviour. Code 0x07 drives the pins from latch contents but keeps the boundary register out of the path, so those latch values can only be set beforehand through the sample/preload code. Only then does the clamp switch on. The stimulus preloads a random pattern under 0x02 and checks that the pins stay normal. It then loads 0x07 and runs a full bypass scan with an update strobe. Finally it checks that the pins still show the preloaded pattern, so the update was ignored. Random rounds repeat this chain of instructions, with bit 7 set at random.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TEST   = 2'd1,
    MODE_HIZ    = 2'd2
  } dev_mode_e;

  typedef struct packed {
    logic      sel_bsr;
    dev_mode_e mode;
  } instr_dec_t;

  // Opcode decode; bit 7 of the instruction is never looked at.
  function automatic instr_dec_t decode_instr(input logic [7:0] code);
    instr_dec_t d;
    case (code[6:0])
      7'h00, 7'h03: d = '{sel_bsr: 1'b1, mode: MODE_TEST};
      7'h02:        d = '{sel_bsr: 1'b1, mode: MODE_NORMAL};
      7'h06:        d = '{sel_bsr: 1'b0, mode: MODE_HIZ};
      7'h07:        d = '{sel_bsr: 1'b0, mode: MODE_TEST};
      default:      d = '{sel_bsr: 1'b0, mode: MODE_NORMAL};
    endcase
    return d;
  endfunction

  function automatic instr_dec_t reset_instr();
    return '{sel_bsr: 1'b0, mode: MODE_NORMAL};
  endfunction
endpackage

// File: rtl/bsc_cell.sv
module bsc_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic si,
  output logic so,
  output logic upd_q
);
  logic sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= 1'b0;
    else if (cap_en)   sh_q <= cap_d;
    else if (shift_en) sh_q <= si;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_q <= 1'b0;
    else if (upd_en) upd_q <= sh_q;
  end

  assign so = sh_q;
endmodule

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_ir,
  input  logic [7:0] ir_val,
  output instr_dec_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= reset_instr();
    else if (upd_ir) cur <= decode_instr(ir_val);
  end
endmodule

// File: rtl/bsc_core.sv
module bsc_core #(
  parameter int WIDTH  = 8,
  parameter int GROUPS = 2
) (
  input  logic [WIDTH-1:0]  a,
  input  logic [GROUPS-1:0] oe_n,
  output logic [WIDTH-1:0]  y,
  output logic [WIDTH-1:0]  y_en
);
  localparam int GW = WIDTH / GROUPS;

  assign y = ~a;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign y_en[g*GW +: GW] = {GW{~oe_n[g]}};
  end
endmodule

// File: rtl/tbuf_scan_wrap.sv
module tbuf_scan_wrap
  import bsc_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int GROUPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  input  logic              upd_ir,
  input  logic [7:0]        ir_val,
  input  logic              tdi,
  output logic              tdo,
  input  logic [WIDTH-1:0]  pin_a,
  input  logic [GROUPS-1:0] pin_oe_n,
  output logic [WIDTH-1:0]  pin_y,
  output logic [WIDTH-1:0]  pin_y_oe
);
  localparam int A_LO    = GROUPS;
  localparam int Y_LO    = GROUPS + WIDTH;
  localparam int BSR_LEN = GROUPS + 2 * WIDTH;

  instr_dec_t cur;
  dev_mode_e  dev_mode;
  logic       bsr_sel;
  logic       use_cells;
  logic       bsr_cap, bsr_shift, bsr_update;
  logic       byp_q;

  logic [BSR_LEN-1:0] chain_q, chain_si, cap_vec, lat;
  logic [WIDTH-1:0]   core_a, core_y, core_en;
  logic [GROUPS-1:0]  core_oe_n;

  bsc_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_ir (upd_ir),
    .ir_val (ir_val),
    .cur    (cur)
  );

  assign dev_mode   = cur.mode;
  assign bsr_sel    = cur.sel_bsr;
  assign use_cells  = (dev_mode != MODE_NORMAL);
  assign bsr_cap    = cap_dr   & bsr_sel;
  assign bsr_shift  = shift_dr & bsr_sel;
  assign bsr_update = upd_dr   & bsr_sel;

  // Core sees pins or input-cell latches
  assign core_a    = use_cells ? lat[A_LO +: WIDTH] : pin_a;
  assign core_oe_n = use_cells ? lat[0 +: GROUPS]   : pin_oe_n;

  bsc_core #(.WIDTH(WIDTH), .GROUPS(GROUPS)) u_core (
    .a    (core_a),
    .oe_n (core_oe_n),
    .y    (core_y),
    .y_en (core_en)
  );

  assign cap_vec = {core_y, pin_a, pin_oe_n};

  for (genvar k = 0; k < BSR_LEN; k++) begin : g_cell
    if (k == BSR_LEN - 1) begin : g_head
      assign chain_si[k] = tdi;
    end else begin : g_body
      assign chain_si[k] = chain_q[k+1];
    end
    bsc_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (bsr_cap),
      .shift_en (bsr_shift),
      .upd_en   (bsr_update),
      .cap_d    (cap_vec[k]),
      .si       (chain_si[k]),
      .so       (chain_q[k]),
      .upd_q    (lat[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   byp_q <= 1'b0;
    else if (cap_dr && !bsr_sel)  byp_q <= 1'b0;
    else if (shift_dr && !bsr_sel) byp_q <= tdi;
  end

  assign tdo      = bsr_sel ? chain_q[0] : byp_q;
  assign pin_y    = use_cells ? lat[Y_LO +: WIDTH] : core_y;
  assign pin_y_oe = (dev_mode == MODE_HIZ) ? '0 : core_en;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
  import bsc_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int BSR_LEN = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cap_dr,
  input logic               shift_dr,
  input logic               upd_dr,
  input logic               upd_ir,
  input logic               tdi,
  input logic               tdo,
  input logic               bsr_sel,
  input dev_mode_e          dev_mode,
  input logic [BSR_LEN-1:0] lat,
  input logic [WIDTH-1:0]   pin_y,
  input logic [WIDTH-1:0]   pin_y_oe
);
  a_r6_hiz_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mode == MODE_HIZ) |-> (pin_y_oe == '0));

  a_r7_clamp_from_cells: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mode == MODE_TEST && !bsr_sel) |-> (pin_y == lat[BSR_LEN-1 -: WIDTH]));

  a_r8_bypass_capture_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_dr && !shift_dr && !upd_ir && !bsr_sel) |=> (tdo == 1'b0));

  a_r8_bypass_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && !cap_dr && !upd_ir && !bsr_sel) |=> (tdo == $past(tdi)));

  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_dr && bsr_sel) |=> $stable(lat));

  a_r12_instr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_ir |=> ($stable(bsr_sel) && $stable(dev_mode)));
endmodule

bind tbuf_scan_wrap bsc_checker #(.WIDTH(WIDTH), .BSR_LEN(BSR_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_dr   (cap_dr),
  .shift_dr (shift_dr),
  .upd_dr   (upd_dr),
  .upd_ir   (upd_ir),
  .tdi      (tdi),
  .tdo      (tdo),
  .bsr_sel  (bsr_sel),
  .dev_mode (dev_mode),
  .lat      (lat),
  .pin_y    (pin_y),
  .pin_y_oe (pin_y_oe)
);

// File: tb/tbuf_scan_wrap_tb.sv
module tbuf_scan_wrap_tb;
  localparam int N = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_dr = 0, shift_dr = 0, upd_dr = 0, upd_ir = 0, tdi = 0;
  logic [7:0] ir_val = 8'h00;
  logic [7:0] pin_a = 8'h00;
  logic [1:0] pin_oe_n = 2'b00;
  logic       tdo;
  logic [7:0] pin_y, pin_y_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model
  bit          m_sel;
  int          m_mode; // 0 normal, 1 test, 2 hiz
  logic [17:0] m_lat;

  always #2.5 clk = ~clk;

  tbuf_scan_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .cap_dr(cap_dr), .shift_dr(shift_dr),
    .upd_dr(upd_dr), .upd_ir(upd_ir), .ir_val(ir_val), .tdi(tdi), .tdo(tdo),
    .pin_a(pin_a), .pin_oe_n(pin_oe_n), .pin_y(pin_y), .pin_y_oe(pin_y_oe)
  );

  function automatic void model_decode(input logic [7:0] c, output bit sel, output int mode);
    logic [6:0] lo = c[6:0];
    if (lo == 7'd0 || lo == 7'd3) begin sel = 1; mode = 1; end
    else if (lo == 7'd2)          begin sel = 1; mode = 0; end
    else if (lo == 7'd6)          begin sel = 0; mode = 2; end
    else if (lo == 7'd7)          begin sel = 0; mode = 1; end
    else                          begin sel = 0; mode = 0; end
  endfunction

  function automatic logic [15:0] model_pins(input int mode, input logic [7:0] a,
                                             input logic [1:0] oe, input logic [17:0] lat);
    logic [7:0] y, en;
    logic [1:0] ce;
    if (mode == 0) begin y = ~a; ce = oe; end
    else begin y = lat[17:10]; ce = lat[1:0]; end
    en = {{4{~ce[1]}}, {4{~ce[0]}}};
    if (mode == 2) en = 8'h00;
    return {y, en};
  endfunction

  function automatic logic [17:0] model_capture(input int mode, input logic [7:0] a,
                                                input logic [1:0] oe, input logic [17:0] lat);
    logic [7:0] ca;
    ca = (mode == 0) ? a : lat[9:2];
    return {~ca, a, oe};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_ir(input logic [7:0] c);
    @(negedge clk); ir_val = c; upd_ir = 1;
    @(negedge clk); upd_ir = 0;
    model_decode(c, m_sel, m_mode);
  endtask

  task automatic dr_scan(input logic [17:0] din, output logic [17:0] dout);
    @(negedge clk); cap_dr = 1;
    @(negedge clk); cap_dr = 0; shift_dr = 1;
    for (int i = 0; i < N; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; upd_dr = 1;
    @(negedge clk); upd_dr = 0;
  endtask

  // full scan with model update and checks on TDO and pins
  task automatic scan_and_check(input string req, input logic [17:0] din);
    logic [17:0] dout, exp;
    if (m_sel) exp = model_capture(m_mode, pin_a, pin_oe_n, m_lat);
    else       exp = {din[16:0], 1'b0};
    dr_scan(din, dout);
    check(req, {14'd0, dout}, {14'd0, exp});
    if (m_sel) m_lat = din;
    check(req, {16'd0, pin_y, pin_y_oe}, {16'd0, model_pins(m_mode, pin_a, pin_oe_n, m_lat)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  codes [0:9];
    logic [17:0] pre;
    void'($urandom(32'h5eed_1149));
    m_sel = 0; m_mode = 0; m_lat = '0;
    codes = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h0E};
    pin_a = 8'hA5; pin_oe_n = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 pins", {16'd0, pin_y, pin_y_oe}, {16'd0, 8'h5A, 8'h0F});
    scan_and_check("R1 R8 bypass after reset", 18'h2B3C1);

    // R12: ir_val changes without upd_ir
    @(negedge clk); ir_val = 8'h00;
    repeat (2) @(negedge clk);
    scan_and_check("R12 no upd_ir", 18'h13579);

    // R4 preload, pins stay normal
    load_ir(8'h02);
    pin_a = 8'h3C; pin_oe_n = 2'b00;
    scan_and_check("R4 R9 sample/preload", 18'h2A55E);
    check("R4 normal pins", {24'd0, pin_y}, {24'd0, 8'hC3});

    // R7 clamp, R11 latches hold during bypass scan
    load_ir(8'h87);
    check("R2 R7 clamp pins", {16'd0, pin_y, pin_y_oe},
          {16'd0, model_pins(1, pin_a, pin_oe_n, 18'h2A55E)});
    scan_and_check("R7 R11 clamp bypass scan", 18'h3FFFF);
    check("R11 latch held", {24'd0, pin_y}, {24'd0, 8'hA9});

    // R6 highz
    load_ir(8'h06);
    check("R6 hiz", {24'd0, pin_y_oe}, {24'd0, 8'h00});
    scan_and_check("R6 hiz bypass scan", 18'h00F0F);

    // R3 / R10 extest
    load_ir(8'h03);
    scan_and_check("R3 R10 extest", 18'h0C3A4);
    scan_and_check("R3 R9 R10 extest capture", 18'h31234);

    // R5 unlisted code
    load_ir(8'h55);
    scan_and_check("R5 unlisted bypass", 18'h15555);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      logic [7:0] c;
      c = codes[$urandom_range(0, 9)];
      if ($urandom_range(0, 1) == 1) c[7] = 1'b1;
      if ($urandom_range(0, 7) == 0) c = 8'($urandom_range(0, 255));
      load_ir(c);
      pin_a = 8'($urandom); pin_oe_n = 2'($urandom);
      pre = 18'($urandom);
      scan_and_check("R2 R3 R5 R8 R9 R10 R11 random", pre);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule